// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block turns a fractional modulation index from a control loop into a switching waveform whose edges fall on quarter-clock boundaries. Each PWM period lasts a fixed number of system clocks. On every clock the block emits a small vector that gives the output level in each quarter of that clock. An external serializer or a set of phase-shifted clocks then places the edge on the pin.

A scaling stage captures the index on a load strobe and multiplies it into a pulse width, counted in quarter-clock slots and held with a fixed-point fraction. At every period start a dithering stage adds the running rounding residue to that exact width. It rounds the sum to the nearest whole slot and keeps the new residue. Over many periods the mean pulse width follows the request to the precision of the fraction, not to the quarter-slot grid.

A synchronisation input restarts the period at once, so that several converters can be aligned. A one-clock strobe marks the first clock of each period.

Top module: `hrpwm_dither_top`

## Requirements
- R1: While `rst` is high, `pwm_q` is 0 and `period_start` is 0, and the residue and scaled index are cleared. The first clock after `rst` falls is the start of a period with width 0.
- R2: A period lasts `CLK_PER_PWM` (default 500) clocks. `period_start` is high for exactly the first clock of each period.
- R3: In clock p of a period (p = 0 at `period_start`), `pwm_q[i]` is 1 exactly when slot 4p+i is below the latched width. Bit 0 is the earliest quarter, so the high part always begins at slot 0.
- R4: At each period start the width becomes floor(T/65536 + 1/2), where T = idx*2000 + E and E is the residue in units of 1/65536 slot. For example, idx 32802 straight after reset gives 1001.
- R5: After each period start the residue becomes T - width*65536. For index 1024, starting from reset, the four periods after the load have widths 31, 32, 31, 31 (sum 125).
- R6: The width is clamped to 0..2000 slots. For index 0xFFFF, starting from reset, the first 16 periods are 2000 slots wide (output high throughout) and the 17th is 1999.
- R7: A high `idx_ld` captures `idx_i` on that clock edge. The new value is first used at the next period start after that edge. A load on the same edge as a period start does not affect that start.
- R8: A high `sync_i` makes the next clock the start of a period, with `period_start` high. The residue advances exactly once for that start, including when it coincides with the natural end of a period.
- R9: The width stays constant within a period. A load in mid-period does not change the waveform of that period.
- R10: An index of 0 produces an output that is all low over the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| idx_i | input | IDX_W (16) | Unsigned fractional modulation index |
| idx_ld | input | 1 | Load strobe for `idx_i` |
| sync_i | input | 1 | Restart the period on the next clock |
| pwm_q | output | PHASES (4) | Output level per quarter of the current clock, bit 0 first |
| period_start | output | 1 | High on the first clock of each period |

## Verification
Two functions can fall on the same edge: the period start, which latches the width and advances the residue, and either a load strobe or a synchronisation request. The bench drives `idx_ld` on the last clock of a period and expects the previous index to set the next period's width. It drives `sync_i` on that same last clock and expects a single residue step. It judges both against a cycle-by-cycle model of the rounding recurrence, which predicts every quarter-slot level of the following periods.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;

    // Default geometry of the generator
    localparam int DEF_IDX_W       = 16;
    localparam int DEF_CLK_PER_PWM = 500;
    localparam int DEF_PHASES      = 4;

    // Why the period counter returns to slot 0 on a given edge
    typedef enum logic [1:0] {
        ADV_HOLD = 2'd0,
        ADV_WRAP = 2'd1,
        ADV_SYNC = 2'd2
    } adv_e;

    function automatic int steps_of(input int clks, input int phases);
        return clks * phases;
    endfunction

endpackage

// File: rtl/hrpwm_scale.sv
module hrpwm_scale #(
    parameter int IDX_W   = 16,
    parameter int STEPS   = 2000,
    parameter int EXACT_W = 27
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld,
    input  logic [IDX_W-1:0]   idx,
    output logic [EXACT_W-1:0] exact_q
);
    localparam logic [EXACT_W-1:0] STEPS_V = EXACT_W'(STEPS);

    // Width in slots with IDX_W fraction bits: idx * STEPS / 2^IDX_W
    always_ff @(posedge clk) begin
        if (rst) begin
            exact_q <= '0;
        end else if (ld) begin
            exact_q <= EXACT_W'(idx) * STEPS_V;
        end
    end
endmodule

// File: rtl/hrpwm_dither.sv
module hrpwm_dither #(
    parameter int EXACT_W = 27,
    parameter int FRAC_W  = 16,
    parameter int STEPS   = 2000,
    parameter int CNT_W   = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [EXACT_W-1:0] exact,
    output logic [CNT_W-1:0]   cnt_next
);
    localparam int TGT_W = EXACT_W + 2;
    localparam logic signed [TGT_W-1:0] HALF    = TGT_W'(1) << (FRAC_W - 1);
    localparam logic signed [TGT_W-1:0] ERR_MAX = HALF - TGT_W'(1);
    localparam logic signed [TGT_W-1:0] ERR_MIN = -HALF;
    localparam logic signed [TGT_W-1:0] STEPS_S = TGT_W'(STEPS);

    logic signed [FRAC_W:0]  err_q;
    logic signed [FRAC_W:0]  err_n;
    logic signed [TGT_W-1:0] tgt;
    logic signed [TGT_W-1:0] rnd;
    logic signed [TGT_W-1:0] sat_fx;
    logic signed [TGT_W-1:0] resid;
    logic        [CNT_W-1:0] cnt;

    // Exact request plus carried residue
    assign tgt = $signed({2'b00, exact})
               + $signed({{(TGT_W-FRAC_W-1){err_q[FRAC_W]}}, err_q});
    // Round to nearest slot, ties upward
    assign rnd = (tgt + HALF) >>> FRAC_W;

    always_comb begin
        if (rnd[TGT_W-1]) begin
            cnt = '0;
        end else if (rnd > STEPS_S) begin
            cnt = CNT_W'(STEPS);
        end else begin
            cnt = rnd[CNT_W-1:0];
        end
    end

    // Residue measured against the clamped count
    assign sat_fx = $signed({{(TGT_W-CNT_W){1'b0}}, cnt}) <<< FRAC_W;
    assign resid  = tgt - sat_fx;

    always_comb begin
        if (resid > ERR_MAX) begin
            err_n = ERR_MAX[FRAC_W:0];
        end else if (resid < ERR_MIN) begin
            err_n = ERR_MIN[FRAC_W:0];
        end else begin
            err_n = resid[FRAC_W:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (adv) begin
            err_q <= err_n;
        end
    end

    assign cnt_next = cnt;
endmodule

// File: rtl/hrpwm_gen.sv
module hrpwm_gen
    import hrpwm_pkg::*;
#(
    parameter int CLK_PER_PWM = 500,
    parameter int NPH         = 4,
    parameter int CNT_W       = 11,
    parameter int POS_W       = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             adv,
    output logic [NPH-1:0]   lvl_q,
    output logic             start_q,
    output logic [POS_W-1:0] pos_q,
    output logic [CNT_W-1:0] wid_q
);
    localparam logic [POS_W-1:0] LAST = POS_W'(CLK_PER_PWM - 1);

    adv_e             kind;
    logic [POS_W-1:0] pos_n;
    logic [CNT_W-1:0] wid_n;
    logic [NPH-1:0]   lvl_n;

    always_comb begin
        if (sync) begin
            kind = ADV_SYNC;
        end else if (pos_q == LAST) begin
            kind = ADV_WRAP;
        end else begin
            kind = ADV_HOLD;
        end
    end

    assign adv   = (kind != ADV_HOLD);
    assign pos_n = adv ? '0 : pos_q + POS_W'(1);
    assign wid_n = adv ? cnt_next : wid_q;

    // One comparator per quarter of the clock
    for (genvar i = 0; i < NPH; i++) begin : g_ph
        assign lvl_n[i] = (CNT_W'(pos_n) * CNT_W'(NPH) + CNT_W'(i)) < wid_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= LAST;
            wid_q   <= '0;
            lvl_q   <= '0;
            start_q <= 1'b0;
        end else begin
            pos_q   <= pos_n;
            wid_q   <= wid_n;
            lvl_q   <= lvl_n;
            start_q <= adv;
        end
    end
endmodule

// File: rtl/hrpwm_dither_top.sv
module hrpwm_dither_top
    import hrpwm_pkg::*;
#(
    parameter int IDX_W       = DEF_IDX_W,
    parameter int CLK_PER_PWM = DEF_CLK_PER_PWM,
    parameter int PHASES      = DEF_PHASES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              idx_ld,
    input  logic              sync_i,
    output logic [PHASES-1:0] pwm_q,
    output logic              period_start
);
    localparam int STEPS   = steps_of(CLK_PER_PWM, PHASES);
    localparam int CNT_W   = $clog2(STEPS + 1);
    localparam int POS_W   = $clog2(CLK_PER_PWM);
    localparam int FRAC_W  = IDX_W;
    localparam int EXACT_W = IDX_W + CNT_W;

    logic [EXACT_W-1:0] exact;
    logic [CNT_W-1:0]   cnt_next;
    logic               adv;
    logic [POS_W-1:0]   gen_pos;
    logic [CNT_W-1:0]   gen_wid;

    hrpwm_scale #(
        .IDX_W  (IDX_W),
        .STEPS  (STEPS),
        .EXACT_W(EXACT_W)
    ) u_scale (
        .clk    (clk),
        .rst    (rst),
        .ld     (idx_ld),
        .idx    (idx_i),
        .exact_q(exact)
    );

    hrpwm_dither #(
        .EXACT_W(EXACT_W),
        .FRAC_W (FRAC_W),
        .STEPS  (STEPS),
        .CNT_W  (CNT_W)
    ) u_dither (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .exact   (exact),
        .cnt_next(cnt_next)
    );

    hrpwm_gen #(
        .CLK_PER_PWM(CLK_PER_PWM),
        .NPH        (PHASES),
        .CNT_W      (CNT_W),
        .POS_W      (POS_W)
    ) u_gen (
        .clk     (clk),
        .rst     (rst),
        .sync    (sync_i),
        .cnt_next(cnt_next),
        .adv     (adv),
        .lvl_q   (pwm_q),
        .start_q (period_start),
        .pos_q   (gen_pos),
        .wid_q   (gen_wid)
    );
endmodule

// File: rtl/hrpwm_chk.sv
module hrpwm_chk #(
    parameter int PHASES = 4,
    parameter int CNT_W  = 11,
    parameter int POS_W  = 9,
    parameter int STEPS  = 2000
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_i,
    input logic [PHASES-1:0] pwm_q,
    input logic              period_start,
    input logic [POS_W-1:0]  pos,
    input logic [CNT_W-1:0]  wid
);
    // R1: reset forces the outputs low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (pwm_q == '0 && !period_start));

    // R8: synchronisation yields a start strobe on the next clock
    a_r8_sync_starts: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> period_start);

    // R2: the strobe is a single clock unless restarted again
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (period_start && !sync_i) |=> !period_start);

    // R2: the strobe marks clock zero of the period counter
    a_r2_strobe_at_zero: assert property (@(posedge clk) disable iff (rst)
        period_start |-> (pos == '0));

    // R9: the latched width changes only where a period begins
    a_r9_width_held: assert property (@(posedge clk) disable iff (rst)
        !period_start |-> $stable(wid));

    // R6: the latched width stays within one period of slots
    a_r6_width_range: assert property (@(posedge clk) disable iff (rst)
        wid <= CNT_W'(STEPS));

    // R3: quarters fill from bit 0 upward
    a_r3_thermometer: assert property (@(posedge clk) disable iff (rst)
        ((pwm_q + PHASES'(1)) & pwm_q) == '0);

    // R10: a zero width keeps every quarter low
    a_r10_zero_low: assert property (@(posedge clk) disable iff (rst)
        (wid == '0) |-> (pwm_q == '0));
endmodule

bind hrpwm_dither_top hrpwm_chk #(
    .PHASES(PHASES),
    .CNT_W (CNT_W),
    .POS_W (POS_W),
    .STEPS (STEPS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_i      (sync_i),
    .pwm_q       (pwm_q),
    .period_start(period_start),
    .pos         (gen_pos),
    .wid         (gen_wid)
);

// File: tb/tb_hrpwm_dither_top.sv
module tb_hrpwm_dither_top;
    localparam int NCLK  = 500;
    localparam int NSLOT = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] idx_i = '0;
    logic        idx_ld = 1'b0;
    logic        sync_i = 1'b0;
    logic [3:0]  pwm_q;
    logic        period_start;

    int n_tests = 0;
    int n_fail  = 0;
    int err_m   = 0;
    int live_idx = 0;
    int next_w  = 0;
    int last_ones = 0;
    bit done = 1'b0;

    hrpwm_dither_top dut (
        .clk         (clk),
        .rst         (rst),
        .idx_i       (idx_i),
        .idx_ld      (idx_ld),
        .sync_i      (sync_i),
        .pwm_q       (pwm_q),
        .period_start(period_start)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Rounding recurrence of R4/R5/R6
    function automatic int model_step(input int idx);
        int tgt = idx * NSLOT + err_m;
        int r = (tgt + 32768) / 65536;
        if (r < 0) r = 0;
        if (r > NSLOT) r = NSLOT;
        err_m = tgt - r * 65536;
        return r;
    endfunction

    // Assumes we stand at the negedge of a period's first clock
    task automatic run_period(input int ld_pos, input int ld_val,
                              input int sync_pos, input string req);
        int w = next_w;
        int ones = 0;
        bit bad = 1'b0;
        int act = 0;
        int exp = 0;
        int last = (sync_pos >= 0 && sync_pos < NCLK) ? sync_pos : NCLK - 1;
        for (int p = 0; p <= last; p++) begin
            logic [3:0] ep;
            logic       es;
            for (int i = 0; i < 4; i++) ep[i] = ((p * 4 + i) < w);
            es = (p == 0);
            if (!bad && (period_start !== es || pwm_q !== ep)) begin
                bad = 1'b1;
                act = {27'd0, period_start, pwm_q};
                exp = {27'd0, es, ep};
                $display("  at clock %0d of period (width %0d)", p, w);
            end
            ones += $countones(pwm_q);
            if (p == last) next_w = model_step(live_idx);
            if (p == ld_pos) begin
                idx_ld = 1'b1;
                idx_i  = 16'(ld_val);
            end
            if (p == sync_pos) sync_i = 1'b1;
            @(negedge clk);
            idx_ld = 1'b0;
            sync_i = 1'b0;
            if (p == ld_pos) live_idx = ld_val;
        end
        last_ones = ones;
        chk(!bad, req, "period waveform {start,pwm}", act, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idx_ld = 1'b0;
        sync_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(pwm_q == 4'd0 && period_start == 1'b0, "R1", "outputs in reset",
            {27'd0, period_start, pwm_q}, 0);
        rst = 1'b0;
        err_m = 0;
        live_idx = 0;
        next_w = model_step(0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        run_period(-1, 0, -1, "R1");
        run_period(-1, 0, -1, "R2");
    endtask

    task automatic t_shape();
        do_reset();
        run_period(3, 32802, -1, "R9");
        run_period(-1, 0, -1, "R3");
        chk(last_ones == 1001, "R4", "slots high for idx 32802", last_ones, 1001);
    endtask

    task automatic t_dither();
        int w[4];
        int sum = 0;
        do_reset();
        run_period(10, 1024, -1, "R9");
        for (int k = 0; k < 4; k++) begin
            run_period(-1, 0, -1, "R5");
            w[k] = last_ones;
            sum += last_ones;
        end
        chk(w[0] == 31 && w[1] == 32 && w[2] == 31 && w[3] == 31, "R5",
            "dither sequence packed", w[0] * 1000000 + w[1] * 10000 + w[2] * 100 + w[3],
            31323131);
        chk(sum == 125, "R5", "sum of four widths", sum, 125);
    endtask

    task automatic t_full();
        int first = 0;
        do_reset();
        run_period(0, 65535, -1, "R6");
        for (int k = 0; k < 16; k++) begin
            run_period(-1, 0, -1, "R6");
            if (k == 0) first = last_ones;
        end
        chk(first == 2000, "R6", "full-scale first width", first, 2000);
        run_period(-1, 0, -1, "R6");
        chk(last_ones == 1999, "R6", "full-scale 17th width", last_ones, 1999);
    endtask

    task automatic t_zero();
        run_period(100, 0, -1, "R10");
        run_period(-1, 0, -1, "R10");
        chk(last_ones == 0, "R10", "zero index slots high", last_ones, 0);
    endtask

    task automatic t_load_wrap();
        run_period(200, 1024, -1, "R7");
        run_period(NCLK - 1, 40000, -1, "R7");
        run_period(-1, 0, -1, "R7");
        run_period(-1, 0, -1, "R7");
        chk(last_ones >= 1220 && last_ones <= 1221, "R7", "width after late load",
            last_ones, 1221);
    endtask

    task automatic t_sync();
        run_period(-1, 0, 137, "R8");
        run_period(-1, 0, -1, "R8");
        run_period(-1, 0, NCLK - 1, "R8");
        run_period(-1, 0, -1, "R8");
        run_period(-1, 0, 0, "R8");
        run_period(-1, 0, -1, "R8");
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_shape();
        t_dither();
        t_full();
        t_zero();
        t_load_wrap();
        t_sync();
        t_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule